// File: doc/BRIEF.md
# Integer Multiply Execution Stage

This block is the combinational multiply stage of a 64-bit integer datapath. It takes two register operands and an optional immediate that, when marked valid, stands in for the second operand. It forms either the low or the high part of the product at 32-bit or 64-bit width, signed or unsigned. It also reports whether a low-part product overflows its destination, and it carries the summary-overflow flag through unchanged.

Signed products are built in sign-magnitude form. Each operand's magnitude is taken at the active width. The magnitudes are multiplied, and the product is negated when exactly one operand is negative. The overflow test checks whether every product bit from the destination sign bit upward holds the same value. The single flag that results drives both bits of the two-bit overflow field.

Top module: `int_mul_unit`

## Requirements
- R1: With `op_sel` = 2'b01 (high group) and `word_mode` = 1, `result[31:0]` and `result[63:32]` both equal bits 63..32 of the 64-bit product of the two 32-bit operands.
- R2: With `op_sel` = 2'b01 and `word_mode` = 0, `result` equals bits 127..64 of the 128-bit product of the two 64-bit operands.
- R3: With the low group and `word_mode` = 1, `result` equals the full 64-bit product of the two 32-bit operands.
- R4: With the low group and `word_mode` = 0, `result` equals the low 64 bits of the signed 128-bit product, whatever the value of `signed_op`.
- R5: Signed operation treats bit 31 (word mode) or bit 63 (double mode) as the sign. The result is the exact two's-complement product, including for the most negative operand values.
- R6: Unsigned operation (`signed_op` = 0, outside 64-bit low mode) zero-extends both operands at the active width.
- R7: In 32-bit low mode, `ov_out` is 2'b11 when product bits 63..31 are neither all zero nor all one, and 2'b00 otherwise.
- R8: In 64-bit low mode, `ov_out` is 2'b11 when product bits 127..63 are neither all zero nor all one, and 2'b00 otherwise.
- R9: In the high group, `ov_out` is 2'b00.
- R10: `so_out` always equals `so_in`.
- R11: When `imm_valid` = 1, `imm_val` replaces `src_b` as the second operand in every operation group. At the active width it is treated like a register operand.
- R12: The `op_sel` encoding is 2'b00 low, 2'b01 high, 2'b10 low with immediate, and 2'b11 behaves as low. Encodings 2'b00, 2'b10 and 2'b11 all give the same outputs for the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm_val | input | 64 | Immediate operand |
| imm_valid | input | 1 | Selects `imm_val` in place of `src_b` |
| op_sel | input | 2 | Operation group (low / high / low-immediate) |
| word_mode | input | 1 | 1 = 32-bit operation, 0 = 64-bit |
| signed_op | input | 1 | 1 = signed operands |
| so_in | input | 1 | Incoming summary-overflow flag |
| result | output | 64 | Selected product part |
| ov_out | output | 2 | Overflow pair, both bits equal |
| so_out | output | 1 | Outgoing summary-overflow flag |

## Verification
The bench builds the unit with its default data width of 64, so both the 32-bit and 64-bit paths are reached. This covers the full 128-bit high part and the 65-bit overflow window. Random operands are biased toward small magnitudes, all-ones and sign-boundary values. This makes fitting and overflowing products both common, alongside directed runs with the most negative operands, zero and the immediate path.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    MOP_LOW  = 2'b00,
    MOP_HIGH = 2'b01,
    MOP_LOWI = 2'b10,
    MOP_RSVD = 2'b11
  } mul_op_e;

  function automatic logic is_high_group(input logic [1:0] op);
    return mul_op_e'(op) == MOP_HIGH;
  endfunction
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic            word_mode,
  input  logic            sgn,
  output logic [XLEN-1:0] mag,
  output logic            neg
);
  localparam int HALF = XLEN / 2;

  // magnitude of a HALF-width value, zero-extended
  function automatic logic [XLEN-1:0] mag_half(input logic [HALF-1:0] v, input logic n);
    logic [HALF-1:0] m;
    m = n ? (~v + 1'b1) : v;
    return {{(XLEN-HALF){1'b0}}, m};
  endfunction

  function automatic logic [XLEN-1:0] mag_full(input logic [XLEN-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  logic sign_bit;

  always_comb begin
    sign_bit = word_mode ? raw[HALF-1] : raw[XLEN-1];
    neg      = sgn & sign_bit;
    mag      = word_mode ? mag_half(raw[HALF-1:0], neg) : mag_full(raw, neg);
  end

  // a negative operand never yields a zero magnitude (R5)
  always_comb begin
    if (neg) assert_neg_mag_R5: assert (mag != '0) else $error("negative operand with zero magnitude");
  end
endmodule

// File: rtl/mul_core.sv
module mul_core #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   mag_a,
  input  logic [XLEN-1:0]   mag_b,
  input  logic              neg_a,
  input  logic              neg_b,
  output logic [2*XLEN-1:0] prod
);
  localparam int PW = 2 * XLEN;

  function automatic logic [PW-1:0] mag_mul(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic [PW-1:0] ex, ey;
    ex = {{XLEN{1'b0}}, x};
    ey = {{XLEN{1'b0}}, y};
    return ex * ey;
  endfunction

  function automatic logic [PW-1:0] cond_negate(input logic [PW-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  logic [PW-1:0] prod_mag;
  logic          flip;

  always_comb begin
    prod_mag = mag_mul(mag_a, mag_b);
    flip     = neg_a ^ neg_b;
    prod     = cond_negate(prod_mag, flip);
  end

  // a product with operand signs that differ is negative unless it is zero (R5)
  always_comb begin
    if (flip && prod_mag != '0)
      assert_neg_product_R5: assert (prod[PW-1]) else $error("negated product not negative");
    if (mag_a == '0 || mag_b == '0)
      assert_zero_product_R5: assert (prod == '0) else $error("zero operand gave non-zero product");
  end
endmodule

// File: rtl/mul_ovf_detect.sv
module mul_ovf_detect #(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod,
  input  logic              word_mode,
  input  logic              low_grp,
  output logic [1:0]        ov
);
  localparam int HALF = XLEN / 2;
  localparam int WW   = HALF + 1;
  localparam int DW   = XLEN + 1;

  function automatic logic mixed_w(input logic [WW-1:0] win);
    return (|win) & ~(&win);
  endfunction

  function automatic logic mixed_d(input logic [DW-1:0] win);
    return (|win) & ~(&win);
  endfunction

  logic flag;

  always_comb begin
    if (!low_grp)       flag = 1'b0;
    else if (word_mode) flag = mixed_w(prod[XLEN-1:HALF-1]);
    else                flag = mixed_d(prod[2*XLEN-1:XLEN-1]);
    ov = {2{flag}};
  end

  // a fitting 64-bit product has an upper half that sign-extends its low half (R8)
  always_comb begin
    if (low_grp && !word_mode && ov == 2'b00)
      assert_fit_double_R8: assert (prod[2*XLEN-1:XLEN] == {XLEN{prod[XLEN-1]}})
        else $error("double product reported as fitting but does not");
    if (low_grp && word_mode && ov == 2'b00)
      assert_fit_word_R7: assert (prod[XLEN-1:HALF] == {HALF{prod[HALF-1]}})
        else $error("word product reported as fitting but does not");
  end
endmodule

// File: rtl/mul_result_sel.sv
module mul_result_sel #(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod,
  input  logic              word_mode,
  input  logic              high_grp,
  output logic [XLEN-1:0]   result
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] pick(input logic [2*XLEN-1:0] p, input logic w, input logic h);
    if (!h)     return p[XLEN-1:0];
    else if (w) return {p[XLEN-1:HALF], p[XLEN-1:HALF]};
    else        return p[2*XLEN-1:XLEN];
  endfunction

  always_comb result = pick(prod, word_mode, high_grp);
endmodule

// File: rtl/int_mul_unit.sv
module int_mul_unit
  import mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] imm_val,
  input  logic            imm_valid,
  input  logic [1:0]      op_sel,
  input  logic            word_mode,
  input  logic            signed_op,
  input  logic            so_in,
  output logic [XLEN-1:0] result,
  output logic [1:0]      ov_out,
  output logic            so_out
);
  localparam int HALF = XLEN / 2;
  localparam int NOPS = 2;

  logic            high_grp, low_grp, sgn_eff;
  logic [XLEN-1:0] opnd [NOPS];
  logic [XLEN-1:0] mag  [NOPS];
  logic            neg  [NOPS];
  logic [2*XLEN-1:0] prod;

  always_comb begin
    high_grp = is_high_group(op_sel);
    low_grp  = ~high_grp;
    // the 64-bit low form exists only as a signed operation
    sgn_eff  = signed_op | (low_grp & ~word_mode);
    opnd[0]  = src_a;
    opnd[1]  = imm_valid ? imm_val : src_b;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_prep
    mul_operand_prep #(.XLEN(XLEN)) u_prep (
      .raw       (opnd[g]),
      .word_mode (word_mode),
      .sgn       (sgn_eff),
      .mag       (mag[g]),
      .neg       (neg[g])
    );
  end

  mul_core #(.XLEN(XLEN)) u_core (
    .mag_a (mag[0]),
    .mag_b (mag[1]),
    .neg_a (neg[0]),
    .neg_b (neg[1]),
    .prod  (prod)
  );

  mul_ovf_detect #(.XLEN(XLEN)) u_ovf (
    .prod      (prod),
    .word_mode (word_mode),
    .low_grp   (low_grp),
    .ov        (ov_out)
  );

  mul_result_sel #(.XLEN(XLEN)) u_sel (
    .prod      (prod),
    .word_mode (word_mode),
    .high_grp  (high_grp),
    .result    (result)
  );

  assign so_out = so_in;

  always_comb begin
    if (high_grp)
      assert_high_no_ov_R9: assert (ov_out == 2'b00) else $error("overflow raised in high group");
    if (high_grp && word_mode)
      assert_dup_word_R1: assert (result[XLEN-1:HALF] == result[HALF-1:0]) else $error("word high halves differ");
    assert_ov_pair_R7: assert (ov_out[0] == ov_out[1]) else $error("overflow bits disagree");
  end
endmodule

// File: tb/int_mul_unit_tb.sv
module int_mul_unit_tb;
  logic        clk = 1'b0;
  logic [63:0] src_a, src_b, imm_val;
  logic        imm_valid, word_mode, signed_op, so_in;
  logic [1:0]  op_sel;
  logic [63:0] result;
  logic [1:0]  ov_out;
  logic        so_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  int_mul_unit u_dut (
    .src_a(src_a), .src_b(src_b), .imm_val(imm_val), .imm_valid(imm_valid),
    .op_sel(op_sel), .word_mode(word_mode), .signed_op(signed_op), .so_in(so_in),
    .result(result), .ov_out(ov_out), .so_out(so_out)
  );

  function automatic logic [127:0] ref_prod(input logic [63:0] a, input logic [63:0] b,
                                            input logic w, input logic s);
    logic signed [63:0]  s32a, s32b, p32s;
    logic        [63:0]  u32a, u32b;
    logic signed [127:0] s64a, s64b, p64s;
    logic        [127:0] u64a, u64b;
    if (w) begin
      if (s) begin
        s32a = $signed(a[31:0]); s32b = $signed(b[31:0]);
        p32s = s32a * s32b;
        return {{64{p32s[63]}}, p32s};
      end
      u32a = {32'd0, a[31:0]}; u32b = {32'd0, b[31:0]};
      return {64'd0, u32a * u32b};
    end
    if (s) begin
      s64a = $signed(a); s64b = $signed(b);
      p64s = s64a * s64b;
      return p64s;
    end
    u64a = {64'd0, a}; u64b = {64'd0, b};
    return u64a * u64b;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [63:0] im,
                       input logic iv, input logic [1:0] op, input logic w, input logic s,
                       input logic so, input string req);
    logic [63:0]  bsel, exp_res;
    logic         hi, s_eff, exp_ov;
    logic [127:0] p;
    logic [64:0]  win;
    @(posedge clk);
    src_a = a; src_b = b; imm_val = im; imm_valid = iv;
    op_sel = op; word_mode = w; signed_op = s; so_in = so;
    @(negedge clk);
    bsel  = iv ? im : b;
    hi    = (op == 2'b01);
    s_eff = s | (!hi && !w);
    p     = ref_prod(a, bsel, w, s_eff);
    if (hi) exp_res = w ? {p[63:32], p[63:32]} : p[127:64];
    else    exp_res = p[63:0];
    if (hi)     win = 65'd0;
    else if (w) win = (p[63:31] == 33'd0 || p[63:31] == {33{1'b1}}) ? 65'd0 : 65'd1;
    else        win = (p[127:63] == 65'd0 || p[127:63] == {65{1'b1}}) ? 65'd0 : 65'd1;
    exp_ov = win[0];
    check(req, "result", result, exp_res);
    check(hi ? "R9" : (w ? "R7" : "R8"), "ov", {62'd0, ov_out}, {62'd0, {2{exp_ov}}});
    check("R10", "so", {63'd0, so_out}, {63'd0, so});
  endtask

  function automatic logic [63:0] rnd_val();
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 6)
      0: v = v & 64'hFF;
      1: v = {64{1'b1}} - (v & 64'hF);
      2: v = {32'd0, 1'b1, 31'd0} ^ (v & 64'h7);
      3: v = {1'b1, 63'd0} ^ (v & 64'h7);
      4: v = {{32{v[31]}}, v[31:0]};
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    src_a = '0; src_b = '0; imm_val = '0; imm_valid = 0;
    op_sel = 2'b00; word_mode = 0; signed_op = 0; so_in = 0;
    @(negedge clk);
    // reset-state style check with all inputs zero
    check("R4", "idle result", result, 64'd0);
    check("R9", "idle ov", {62'd0, ov_out}, 64'd0);

    // R5 most negative corners
    apply(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0, 0, 2'b00, 1, 1, 0, "R5 word min*-1");
    apply(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b00, 0, 1, 1, "R5 dbl min*-1");
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 2'b01, 0, 1, 0, "R2 min*min high");
    apply(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, 0, 2'b01, 1, 1, 0, "R1 word min*min high");
    // R6 unsigned high
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b01, 0, 0, 0, "R6 dbl unsigned high");
    apply(64'h1234_5678_FFFF_FFFF, 64'h9ABC_DEF0_FFFF_FFFF, 0, 0, 2'b01, 1, 0, 1, "R6 R1 word unsigned high");
    // R3 unsigned word low overflow / R4 ignores signed bit
    apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 0, 0, 2'b00, 1, 0, 0, "R3 word unsigned low");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 0, 0, 2'b00, 0, 0, 0, "R4 dbl low signed forced");
    // R11 immediate replaces src_b
    apply(64'd7, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFE, 1, 2'b10, 0, 1, 0, "R11 imm low");
    apply(64'd7, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFE, 1, 2'b01, 1, 1, 0, "R11 imm high");
    // R12 reserved encoding behaves as low
    apply(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 0, 0, 2'b11, 0, 0, 1, "R12 op3 as low");
    apply(64'h0, 64'h1234, 0, 0, 2'b00, 1, 1, 0, "R5 zero operand");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      logic       w, s;
      string      rq;
      op = 2'($urandom % 4);
      w  = 1'($urandom % 2);
      s  = 1'($urandom % 2);
      if (op == 2'b01) rq = w ? "R1" : "R2";
      else             rq = w ? "R3" : "R4";
      apply(rnd_val(), rnd_val(), rnd_val(), 1'($urandom % 2), op, w, s, 1'($urandom % 2), rq);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule